// File: doc/BRIEF.md
# Interruptible Guarded Indirect Jump Unit

This block resolves a register-indirect "jump when false" operation inside a wide-issue branch unit. On every cycle it looks at one issue: a valid bit, the slot it came from, an opcode, an optional guard word, a condition word and a jump target. When the operation is recognised and its guard and condition allow the jump, the block starts a fixed branch-delay countdown. The sequential instructions in the delay shadow keep executing, and the redirect is applied only when the countdown ends.

When the countdown ends, the block samples the exception-pending and interrupt-pending lines. If neither line is set, the program counter, the destination counter and the saved counter all load the target. If a line is set, the jump also serves as an interrupt window. Only the destination counter takes the target. The program counter takes the service vector of the winning event, and the block pulses an acknowledge for that event class. An exception always wins over an interrupt.

Top module: `ijmp_unit`

## Requirements
- R1: A jump is taken only when the operation is recognised, bit 0 of the guard is 1 and bit 0 of the condition word is 0. An unguarded issue (`guarded_i`=0) behaves as if the guard bit were 1. Any other case leaves every output unchanged and starts no countdown.
- R2: When the issue is guarded and bit 0 of the guard word is 0, `pc_o`, `dpc_o` and `spc_o` keep their values whatever the condition word holds.
- R3: A taken jump with no event pending at expiry loads the target into `pc_o`, `dpc_o` and `spc_o`, with one `redirect_o` pulse and no acknowledge.
- R4: A taken jump with an event pending at expiry loads the target into `dpc_o` and the matching service vector (`EXC_VEC` or `IRQ_VEC`) into `pc_o`. `spc_o` keeps its value. The matching acknowledge pulses for one cycle, together with `redirect_o`.
- R5: If an exception and an interrupt are both pending at expiry, only the exception is serviced: `pc_o`=`EXC_VEC`, `exc_ack_o` pulses and `irq_ack_o` stays 0.
- R6: The outputs change exactly `DELAY` (3) clock edges after the edge that accepts the issue. They keep their previous values before that edge, and `busy_o` is high during the countdown.
- R7: An operation is recognised only with opcode 181 (`JUMP_OPC`) from issue slots 2, 3 or 4 (bits set in `SLOT_MASK`). Any other opcode or slot is ignored.
- R8: The pending lines are sampled at the expiry edge, not at issue. An event that is pending only at issue has no effect on the jump.
- R9: A recognised operation issued while `busy_o` is high is dropped, and `overlap_err_o` pulses for one cycle. The jump already in flight completes with its own target.
- R10: Reset (`rst_ni` low) clears the countdown and the pulses and sets `pc_o`, `dpc_o` and `spc_o` to `RESET_ADDR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | An operation is issued this cycle |
| issue_slot_i | input | SLOT_W | Issue slot number |
| opcode_i | input | OPC_W | Operation code |
| guarded_i | input | 1 | The issue carries a guard operand |
| guard_i | input | DATA_W | Guard word, bit 0 used |
| cond_i | input | DATA_W | Condition word, bit 0 used |
| target_i | input | ADDR_W | Jump target |
| exc_pending_i | input | 1 | Exception pending |
| irq_pending_i | input | 1 | Interrupt pending |
| pc_o | output | ADDR_W | Program counter |
| dpc_o | output | ADDR_W | Destination counter |
| spc_o | output | ADDR_W | Saved counter |
| redirect_o | output | 1 | Counters were updated on the last edge |
| exc_ack_o | output | 1 | Exception service taken |
| irq_ack_o | output | 1 | Interrupt service taken |
| busy_o | output | 1 | Branch-delay countdown active |
| overlap_err_o | output | 1 | An issue was dropped during the countdown |

## Verification
The assertions assume that the pending lines only matter at the expiry edge. They also assume that the counters change only through the commit path. The vector checks therefore rely on `EXC_VEC` and `IRQ_VEC` being distinct from each other. The stimulus holds the pending lines at the value wanted for the expiry edge, or sets them only around issue to exercise late sampling. Each new jump is issued only after the previous redirect, except in the deliberate overlap sequence. All targets differ from both vectors, so a wrong choice of source for `pc_o` shows up as a value mismatch.

// File: rtl/ijmp_pkg.sv
package ijmp_pkg;
  typedef enum logic [1:0] {
    SVC_NONE = 2'd0,
    SVC_EXC  = 2'd1,
    SVC_IRQ  = 2'd2
  } svc_e;

  typedef struct packed {
    logic recog;
    logic take;
  } dec_t;
endpackage

// File: rtl/ijmp_decode.sv
module ijmp_decode
  import ijmp_pkg::*;
#(
  parameter int unsigned OPC_W     = 8,
  parameter int unsigned SLOT_W    = 3,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned JUMP_OPC  = 181,
  parameter logic [2**SLOT_W-1:0] SLOT_MASK = 8'b0001_1100
) (
  input  logic              valid_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [OPC_W-1:0]  opc_i,
  input  logic              guarded_i,
  input  logic [DATA_W-1:0] guard_i,
  input  logic [DATA_W-1:0] cond_i,
  output dec_t              dec_o
);
  localparam int unsigned NSLOT = 2**SLOT_W;

  logic [NSLOT-1:0] slot_hit;
  logic             unused_hi;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign slot_hit[s] = SLOT_MASK[s] && (slot_i == SLOT_W'(s));
  end

  assign unused_hi = ^{guard_i[DATA_W-1:1], cond_i[DATA_W-1:1]};

  always_comb begin
    dec_o.recog = valid_i && (opc_i == OPC_W'(JUMP_OPC)) && (|slot_hit);
    dec_o.take  = dec_o.recog && (!guarded_i || guard_i[0]) && !cond_i[0];
  end
endmodule

// File: rtl/ijmp_delay.sv
module ijmp_delay #(
  parameter int unsigned DELAY = 3,
  parameter int unsigned PAY_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PAY_W-1:0] pay_i,
  output logic             busy_o,
  output logic             fire_o,
  output logic [PAY_W-1:0] pay_o
);
  localparam int unsigned CNT_W = $clog2(DELAY + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PAY_W-1:0] pay_q;

  assign busy_o = (cnt_q != '0);
  assign fire_o = (cnt_q == CNT_W'(1));
  assign pay_o  = pay_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pay_q <= '0;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (start_i) begin
      cnt_q <= CNT_W'(DELAY);
      pay_q <= pay_i;
    end
  end
endmodule

// File: rtl/ijmp_commit.sv
module ijmp_commit
  import ijmp_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_0100,
  parameter logic [ADDR_W-1:0] EXC_VEC    = 32'h0000_0040,
  parameter logic [ADDR_W-1:0] IRQ_VEC    = 32'h0000_0080
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic              exc_i,
  input  logic              irq_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] dpc_o,
  output logic [ADDR_W-1:0] spc_o,
  output logic              redirect_o,
  output logic              exc_ack_o,
  output logic              irq_ack_o
);
  svc_e svc;

  // exception outranks interrupt
  always_comb begin
    if (exc_i)      svc = SVC_EXC;
    else if (irq_i) svc = SVC_IRQ;
    else            svc = SVC_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o       <= RESET_ADDR;
      dpc_o      <= RESET_ADDR;
      spc_o      <= RESET_ADDR;
      redirect_o <= 1'b0;
      exc_ack_o  <= 1'b0;
      irq_ack_o  <= 1'b0;
    end else begin
      redirect_o <= fire_i;
      exc_ack_o  <= fire_i && (svc == SVC_EXC);
      irq_ack_o  <= fire_i && (svc == SVC_IRQ);
      if (fire_i) begin
        dpc_o <= tgt_i;
        unique case (svc)
          SVC_EXC: pc_o <= EXC_VEC;
          SVC_IRQ: pc_o <= IRQ_VEC;
          default: begin
            pc_o  <= tgt_i;
            spc_o <= tgt_i;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ijmp_unit.sv
module ijmp_unit
  import ijmp_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       OPC_W      = 8,
  parameter int unsigned       SLOT_W     = 3,
  parameter int unsigned       JUMP_OPC   = 181,
  parameter logic [2**SLOT_W-1:0] SLOT_MASK = 8'b0001_1100,
  parameter int unsigned       DELAY      = 3,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_0100,
  parameter logic [ADDR_W-1:0] EXC_VEC    = 32'h0000_0040,
  parameter logic [ADDR_W-1:0] IRQ_VEC    = 32'h0000_0080
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [SLOT_W-1:0] issue_slot_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic              guarded_i,
  input  logic [DATA_W-1:0] guard_i,
  input  logic [DATA_W-1:0] cond_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic              exc_pending_i,
  input  logic              irq_pending_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] dpc_o,
  output logic [ADDR_W-1:0] spc_o,
  output logic              redirect_o,
  output logic              exc_ack_o,
  output logic              irq_ack_o,
  output logic              busy_o,
  output logic              overlap_err_o
);
  dec_t              dec;
  logic              fire;
  logic [ADDR_W-1:0] tgt_q;
  logic              err_q;

  ijmp_decode #(
    .OPC_W(OPC_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W),
    .JUMP_OPC(JUMP_OPC), .SLOT_MASK(SLOT_MASK)
  ) u_decode (
    .valid_i(issue_valid_i), .slot_i(issue_slot_i), .opc_i(opcode_i),
    .guarded_i(guarded_i), .guard_i(guard_i), .cond_i(cond_i),
    .dec_o(dec)
  );

  ijmp_delay #(.DELAY(DELAY), .PAY_W(ADDR_W)) u_delay (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(dec.take),
    .pay_i(target_i), .busy_o(busy_o), .fire_o(fire), .pay_o(tgt_q)
  );

  ijmp_commit #(
    .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR),
    .EXC_VEC(EXC_VEC), .IRQ_VEC(IRQ_VEC)
  ) u_commit (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .tgt_i(tgt_q),
    .exc_i(exc_pending_i), .irq_i(irq_pending_i),
    .pc_o(pc_o), .dpc_o(dpc_o), .spc_o(spc_o),
    .redirect_o(redirect_o), .exc_ack_o(exc_ack_o), .irq_ack_o(irq_ack_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= dec.recog && busy_o;
  end

  assign overlap_err_o = err_q;
endmodule

// File: rtl/ijmp_unit_chk.sv
module ijmp_unit_chk #(
  parameter int unsigned       ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] EXC_VEC = 32'h0000_0040,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 32'h0000_0080
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exc_pending_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] dpc_o,
  input logic [ADDR_W-1:0] spc_o,
  input logic              redirect_o,
  input logic              exc_ack_o,
  input logic              irq_ack_o,
  input logic              busy_o,
  input logic              overlap_err_o
);
  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({exc_ack_o, irq_ack_o})); // R5
  AST_IRQ_YIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> !$past(exc_pending_i)); // R5
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_o |-> $stable(pc_o)); // R2
  AST_DPC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_o |-> $stable(dpc_o)); // R6
  AST_PLAIN_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !exc_ack_o && !irq_ack_o) |-> (pc_o == dpc_o && spc_o == dpc_o)); // R3
  AST_SVC_SPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_ack_o || irq_ack_o) |-> $stable(spc_o)); // R4
  AST_EXC_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_ack_o |-> (redirect_o && pc_o == EXC_VEC)); // R4
  AST_IRQ_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> (redirect_o && pc_o == IRQ_VEC)); // R4
  AST_REDIRECT_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> $past(busy_o)); // R6
  AST_ERR_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overlap_err_o |-> $past(busy_o)); // R9
endmodule

bind ijmp_unit ijmp_unit_chk #(
  .ADDR_W(ADDR_W), .EXC_VEC(EXC_VEC), .IRQ_VEC(IRQ_VEC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .exc_pending_i(exc_pending_i),
  .pc_o(pc_o), .dpc_o(dpc_o), .spc_o(spc_o), .redirect_o(redirect_o),
  .exc_ack_o(exc_ack_o), .irq_ack_o(irq_ack_o), .busy_o(busy_o),
  .overlap_err_o(overlap_err_o)
);

// File: tb/ijmp_unit_bench.sv
module ijmp_unit_bench;
  localparam logic [31:0] RST_A = 32'h0000_0100;
  localparam logic [31:0] EXC_A = 32'h0000_0040;
  localparam logic [31:0] IRQ_A = 32'h0000_0080;
  localparam logic [7:0]  OPC   = 8'd181;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_valid_i = 1'b0;
  logic [2:0]  issue_slot_i = '0;
  logic [7:0]  opcode_i = '0;
  logic        guarded_i = 1'b0;
  logic [31:0] guard_i = '0;
  logic [31:0] cond_i = '0;
  logic [31:0] target_i = '0;
  logic        exc_pending_i = 1'b0;
  logic        irq_pending_i = 1'b0;
  logic [31:0] pc_o, dpc_o, spc_o;
  logic        redirect_o, exc_ack_o, irq_ack_o, busy_o, overlap_err_o;

  ijmp_unit u_ijmp_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .issue_valid_i(issue_valid_i),
    .issue_slot_i(issue_slot_i), .opcode_i(opcode_i), .guarded_i(guarded_i),
    .guard_i(guard_i), .cond_i(cond_i), .target_i(target_i),
    .exc_pending_i(exc_pending_i), .irq_pending_i(irq_pending_i),
    .pc_o(pc_o), .dpc_o(dpc_o), .spc_o(spc_o), .redirect_o(redirect_o),
    .exc_ack_o(exc_ack_o), .irq_ack_o(irq_ack_o), .busy_o(busy_o),
    .overlap_err_o(overlap_err_o)
  );

  always #5 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    int          at;
    logic [31:0] pc, dpc, spc;
    logic        ea, ia;
    string       req;
  } exp_t;
  exp_t sb[$];

  logic [31:0] m_pc = RST_A, m_dpc = RST_A, m_spc = RST_A;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: pops expected redirects
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (redirect_o) begin
        if (sb.size() == 0) begin
          chk(0, "R6 unexpected redirect", pc_o, m_pc);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc == e.at, {e.req, " timing"}, 32'(cyc), 32'(e.at));
          chk(pc_o == e.pc, {e.req, " pc"}, pc_o, e.pc);
          chk(dpc_o == e.dpc, {e.req, " dpc"}, dpc_o, e.dpc);
          chk(spc_o == e.spc, {e.req, " spc"}, spc_o, e.spc);
          chk(exc_ack_o == e.ea, {e.req, " exc_ack"}, 32'(exc_ack_o), 32'(e.ea));
          chk(irq_ack_o == e.ia, {e.req, " irq_ack"}, 32'(irq_ack_o), 32'(e.ia));
        end
      end else if (sb.size() != 0 && sb[0].at < cyc) begin
        chk(0, {sb[0].req, " missing redirect"}, 32'(cyc), 32'(sb[0].at));
        void'(sb.pop_front());
      end
    end
  end

  task automatic drive(input logic v, input logic [2:0] s, input logic [7:0] o,
                       input logic g, input logic [31:0] gw, input logic [31:0] cw,
                       input logic [31:0] t);
    issue_valid_i = v; issue_slot_i = s; opcode_i = o;
    guarded_i = g; guard_i = gw; cond_i = cw; target_i = t;
  endtask

  function automatic void push(input int at, input logic [31:0] t, input logic ex,
                               input logic iq, input string req);
    exp_t e;
    e.at = at; e.dpc = t; e.req = req;
    e.ea = ex; e.ia = iq && !ex;
    e.pc = ex ? EXC_A : (iq ? IRQ_A : t);
    e.spc = (ex || iq) ? m_spc : t;
    sb.push_back(e);
    m_pc = e.pc; m_dpc = e.dpc; m_spc = e.spc;
  endfunction

  task automatic taken(input logic [2:0] s, input logic g, input logic [31:0] gw,
                       input logic [31:0] cw, input logic [31:0] t,
                       input logic ex_iss, input logic iq_iss,
                       input logic ex_c, input logic iq_c, input string req);
    logic [31:0] old_pc;
    @(negedge clk_i);
    old_pc = m_pc;
    exc_pending_i = ex_iss; irq_pending_i = iq_iss;
    drive(1, s, OPC, g, gw, cw, t);
    push(cyc + 4, t, ex_c, iq_c, req);
    @(negedge clk_i);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk(busy_o == 1'b1, "R6 busy in countdown", 32'(busy_o), 32'd1);
    @(negedge clk_i);
    @(negedge clk_i);
    chk(pc_o == old_pc, "R6 pc before expiry", pc_o, old_pc);
    exc_pending_i = ex_c; irq_pending_i = iq_c;
    @(negedge clk_i);
    exc_pending_i = 0; irq_pending_i = 0;
    @(negedge clk_i);
  endtask

  task automatic not_taken(input logic [2:0] s, input logic [7:0] o, input logic g,
                           input logic [31:0] gw, input logic [31:0] cw, input string req);
    @(negedge clk_i);
    drive(1, s, o, g, gw, cw, 32'h0000_9999);
    @(negedge clk_i);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk(busy_o == 1'b0, {req, " no countdown"}, 32'(busy_o), 32'd0);
    repeat (4) @(negedge clk_i);
    chk(pc_o == m_pc, {req, " pc held"}, pc_o, m_pc);
    chk(dpc_o == m_dpc, {req, " dpc held"}, dpc_o, m_dpc);
    chk(spc_o == m_spc, {req, " spc held"}, spc_o, m_spc);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    chk(0, "watchdog", 32'(cyc), 32'd0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(pc_o == RST_A, "R10 pc", pc_o, RST_A);
    chk(dpc_o == RST_A, "R10 dpc", dpc_o, RST_A);
    chk(spc_o == RST_A, "R10 spc", spc_o, RST_A);
    chk(!busy_o && !overlap_err_o && !redirect_o, "R10 flags",
        32'({busy_o, overlap_err_o, redirect_o}), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    taken(3'd2, 1, 32'h1, 32'h0, 32'h0000_0330, 0, 0, 0, 0, "R3");
    taken(3'd3, 0, 32'h0, 32'h2, 32'h0000_1234, 0, 0, 0, 0, "R1");
    not_taken(3'd2, OPC, 1, 32'h1, 32'h1, "R1");
    not_taken(3'd3, OPC, 0, 32'h0, 32'hFFFF_FFFF, "R1");
    not_taken(3'd4, OPC, 1, 32'h0, 32'h0, "R2");
    not_taken(3'd2, OPC, 1, 32'hFFFF_FFFE, 32'h1, "R2");
    not_taken(3'd1, OPC, 1, 32'h1, 32'h0, "R7");
    not_taken(3'd5, OPC, 1, 32'h1, 32'h0, "R7");
    not_taken(3'd0, OPC, 0, 32'h0, 32'h0, "R7");
    not_taken(3'd2, 8'd180, 1, 32'h1, 32'h0, "R7");
    taken(3'd4, 1, 32'h3, 32'h0, 32'h0000_8000, 0, 0, 0, 0, "R7");
    taken(3'd2, 1, 32'h1, 32'h0, 32'h0000_2000, 0, 0, 0, 1, "R4");
    taken(3'd3, 1, 32'h1, 32'h0, 32'h0000_3000, 0, 0, 1, 1, "R5");
    taken(3'd4, 0, 32'h0, 32'h0, 32'h0000_4000, 0, 0, 1, 0, "R4");
    taken(3'd2, 1, 32'h1, 32'h0, 32'h0000_5000, 1, 1, 0, 0, "R8");

    // R9 overlap: second issue during countdown is dropped
    @(negedge clk_i);
    drive(1, 3'd2, OPC, 1, 32'h1, 32'h0, 32'h0000_6000);
    push(cyc + 4, 32'h0000_6000, 0, 0, "R9");
    @(negedge clk_i);
    drive(1, 3'd3, OPC, 1, 32'h1, 32'h0, 32'h0000_7000);
    @(negedge clk_i);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk(overlap_err_o == 1'b1, "R9 err pulse", 32'(overlap_err_o), 32'd1);
    @(negedge clk_i);
    chk(overlap_err_o == 1'b0, "R9 err clears", 32'(overlap_err_o), 32'd0);
    repeat (6) @(negedge clk_i);
    chk(pc_o == 32'h0000_6000, "R9 first jump kept", pc_o, 32'h0000_6000);
    chk(sb.size() == 0, "R9 queue drained", 32'(sb.size()), 32'd0);
    report();
  end
endmodule